// File: doc/BRIEF.md
# Wide Register Write Collector

This unit connects a host register bus to a bank of 128-bit control registers and a table memory of 64-bit entries. The host reaches these wide words in 32-bit or 64-bit pieces. Write pieces for a control register go into a staging buffer. The assembled register is handed to the bank in one strobe, and only when the piece carrying its top dword arrives. Table entries are assembled in the same way from two dwords, or arrive whole as one qword.

Reads work the other way. Reading the lowest piece of a wide register takes a snapshot of all 128 live bits into a shadow buffer. The higher pieces are then served from that snapshot, so the host sees one consistent value.

A few designated registers in each 0x2000-byte page accept a lone dword write. That write is passed straight out and leaves any collection in progress untouched. The register space repeats in pages, so the page number forms part of every register index.

Top module: `wide_wr_collector`

## Requirements
- R1: A dword write at byte offset 12 of a 16-byte register slot produces, one cycle later, a one-cycle `wide_we` with `wide_idx` = address bits [14:4] and `wide_data` = {written dword, staged dwords 2, 1, 0}.
- R2: Dword writes at offsets 0, 4 and 8 of a slot only place their data in the staging buffer (dword n at bits 32n+31:32n) and never raise `wide_we`.
- R3: A qword write (byte enables 0xFF) at offset 0 stages dwords 0 and 1. A qword at offset 8 commits {qword, staged low 64 bits} one cycle later.
- R4: A piece for a slot other than the staged one discards the staged data, which is replaced by zeros. The staging buffer is also zeroed after every commit.
- R5: Addresses with bit 15 set form the table, with index = address bits [14:3]. A dword at offset 0 is staged. A dword at offset 4 commits {written, staged} through `tbl_we` one cycle later, and then clears the staged dword. A qword commits at once.
- R6: A dword write to page offset 0x800, 0x810 or 0x820 (select 0, 1, 2) raises `nw_we` one cycle later with that select, the page and the data. It leaves the wide staging buffer unchanged and raises no `wide_we`.
- R7: Register space is paged every 0x2000 bytes. The page number is address bits [14:13], and it is reported on `nw_page` and included in `wide_idx`.
- R8: A read of dword 0, or of the qword at offset 0, returns live register data and copies all 128 bits into a shadow buffer. Reads of dwords 1 to 3, or of the qword at offset 8, return shadow data, even if the live register has changed since the snapshot.
- R9: A high-piece read with no preceding low-piece read of the same register returns the shadow as it stands, with no refresh.
- R10: An access is valid only with byte enables 0x0F on a 4-aligned address or 0xFF on an 8-aligned address. Any other access raises `bus_err` for one cycle and changes no staging, shadow or output strobe. At most one of the strobes, `bus_err` and `bus_rvalid` is high in any cycle.
- R11: A valid read raises `bus_rvalid` one cycle later with the data on `bus_rdata` (dword reads zero-extended). Reads of the table region return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write request this cycle |
| bus_rd | input | 1 | Read request this cycle (ignored if bus_wr) |
| bus_addr | input | ADDR_W (16) | Byte address |
| bus_be | input | 8 | Byte enables: 0x0F dword, 0xFF qword |
| bus_wdata | input | 64 | Write data (dword in bits 31:0) |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 64 | Read data |
| bus_err | output | 1 | One-cycle flag for a rejected access |
| reg_rd_idx | output | ADDR_W-5 (11) | Register index for the live read path |
| reg_rd_data | input | 128 | Live register contents at reg_rd_idx |
| wide_we | output | 1 | Wide register commit strobe |
| wide_idx | output | ADDR_W-5 (11) | Committed register index |
| wide_data | output | 128 | Committed register value |
| tbl_we | output | 1 | Table entry commit strobe |
| tbl_idx | output | ADDR_W-4 (12) | Table entry index |
| tbl_data | output | 64 | Table entry value |
| nw_we | output | 1 | Designated dword register write strobe |
| nw_page | output | ADDR_W-1-PAGE_SHIFT (2) | Page of that write |
| nw_sel | output | 2 | Which designated register (0, 1, 2) |
| nw_data | output | 32 | Written dword |

## Verification
The bench interleaves a designated dword write with a half-built collection. A collector that let the bypass through would lose or corrupt the staged dwords, or commit early. It also switches slots mid-collection and repeats a final piece right after a commit, which catches designs that keep stale low dwords. Live register data is changed between a snapshot read and the high-piece reads, so a design serving live data instead of the shadow returns the newer values. Malformed byte enables are mixed into collections, where a design that did not reject them would stage garbage or fire a strobe.

// File: rtl/wide_wr_collector.sv
module wide_wr_collector #(
  parameter int ADDR_W = 16,
  parameter int PAGE_SHIFT = 13,
  parameter logic [PAGE_SHIFT-1:0] NW_OFS0 = 13'h0800,
  parameter logic [PAGE_SHIFT-1:0] NW_OFS1 = 13'h0810,
  parameter logic [PAGE_SHIFT-1:0] NW_OFS2 = 13'h0820
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [7:0]                     bus_be,
  input  logic [63:0]                    bus_wdata,
  output logic                           bus_rvalid,
  output logic [63:0]                    bus_rdata,
  output logic                           bus_err,
  output logic [ADDR_W-6:0]              reg_rd_idx,
  input  logic [127:0]                   reg_rd_data,
  output logic                           wide_we,
  output logic [ADDR_W-6:0]              wide_idx,
  output logic [127:0]                   wide_data,
  output logic                           tbl_we,
  output logic [ADDR_W-5:0]              tbl_idx,
  output logic [63:0]                    tbl_data,
  output logic                           nw_we,
  output logic [ADDR_W-2-PAGE_SHIFT:0]   nw_page,
  output logic [1:0]                     nw_sel,
  output logic [31:0]                    nw_data
);
  localparam int SLOT_W = ADDR_W - 5;
  localparam int TIDX_W = ADDR_W - 4;

  logic [95:0]        stg;
  logic [SLOT_W-1:0]  stg_slot;
  logic [31:0]        tstg;
  logic [TIDX_W-1:0]  tslot;
  logic [127:0]       shadow;

  wire is_tbl = bus_addr[ADDR_W-1];
  wire is_dw  = (bus_be == 8'h0F) && (bus_addr[1:0] == 2'b00);
  wire is_qw  = (bus_be == 8'hFF) && (bus_addr[2:0] == 3'b000);
  wire good   = is_dw || is_qw;
  wire [PAGE_SHIFT-1:0] ofs = bus_addr[PAGE_SHIFT-1:0];
  wire hit0 = ofs == NW_OFS0;
  wire hit1 = ofs == NW_OFS1;
  wire hit2 = ofs == NW_OFS2;
  wire is_nw = !is_tbl && is_dw && (hit0 || hit1 || hit2);
  wire [SLOT_W-1:0] slot = bus_addr[ADDR_W-2:4];
  wire [TIDX_W-1:0] tidx = bus_addr[ADDR_W-2:3];
  wire [1:0] dsel = bus_addr[3:2];
  wire wr_ok   = bus_wr && good;
  wire wide_go = wr_ok && !is_tbl && !is_nw;
  wire rd_ok   = bus_rd && !bus_wr && good;
  wire rd_low  = is_dw ? (dsel == 2'd0) : !bus_addr[3];

  assign reg_rd_idx = slot;

  logic [95:0]  base, merged;
  logic         fin;
  logic [127:0] fin_data;

  always_comb begin
    base = (slot == stg_slot) ? stg : '0;
    merged = base;
    fin = 1'b0;
    if (is_dw) begin
      if (dsel == 2'd3) fin = 1'b1;
      else merged[dsel*32 +: 32] = bus_wdata[31:0];
    end else begin
      if (bus_addr[3]) fin = 1'b1;
      else merged[63:0] = bus_wdata;
    end
    fin_data = is_dw ? {bus_wdata[31:0], base} : {bus_wdata, base[63:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg <= '0; stg_slot <= '0; tstg <= '0; tslot <= '0; shadow <= '0;
      wide_we <= 1'b0; wide_idx <= '0; wide_data <= '0;
      tbl_we <= 1'b0; tbl_idx <= '0; tbl_data <= '0;
      nw_we <= 1'b0; nw_page <= '0; nw_sel <= '0; nw_data <= '0;
      bus_rvalid <= 1'b0; bus_rdata <= '0; bus_err <= 1'b0;
    end else begin
      wide_we <= 1'b0;
      tbl_we <= 1'b0;
      nw_we <= 1'b0;
      bus_rvalid <= 1'b0;
      bus_err <= (bus_wr || bus_rd) && !good;
      if (wide_go) begin
        stg_slot <= slot;
        if (fin) begin
          wide_we <= 1'b1;
          wide_idx <= slot;
          wide_data <= fin_data;
          stg <= '0;
        end else begin
          stg <= merged;
        end
      end
      if (wr_ok && is_tbl) begin
        if (is_qw) begin
          tbl_we <= 1'b1; tbl_idx <= tidx; tbl_data <= bus_wdata;
        end else if (bus_addr[2]) begin
          tbl_we <= 1'b1; tbl_idx <= tidx;
          tbl_data <= {bus_wdata[31:0], (tslot == tidx) ? tstg : 32'h0};
          tstg <= '0; tslot <= tidx;
        end else begin
          tstg <= bus_wdata[31:0]; tslot <= tidx;
        end
      end
      if (wr_ok && is_nw) begin
        nw_we <= 1'b1;
        nw_page <= bus_addr[ADDR_W-2:PAGE_SHIFT];
        nw_sel <= hit0 ? 2'd0 : (hit1 ? 2'd1 : 2'd2);
        nw_data <= bus_wdata[31:0];
      end
      if (rd_ok) begin
        bus_rvalid <= 1'b1;
        if (is_tbl) begin
          bus_rdata <= '0;
        end else if (rd_low) begin
          shadow <= reg_rd_data;
          bus_rdata <= is_dw ? {32'h0, reg_rd_data[31:0]} : reg_rd_data[63:0];
        end else begin
          bus_rdata <= is_dw ? {32'h0, shadow[dsel*32 +: 32]} : shadow[127:64];
        end
      end
    end
  end

  // R10
  excl_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wide_we, tbl_we, nw_we, bus_err, bus_rvalid}));

  // R2
  low_piece_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_dw && !is_tbl && !is_nw && dsel != 2'd3) |=> !wide_we);

  // R6
  bypass_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_nw) |=> ($stable(stg) && !wide_we && nw_we));

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && !is_tbl && !rd_low) |=> $stable(shadow));

  // R11
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_rd));
endmodule

// File: tb/wide_wr_collector_tb.sv
module wide_wr_collector_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_be = '0;
  logic [63:0] bus_wdata = '0;
  logic bus_rvalid, bus_err, wide_we, tbl_we, nw_we;
  logic [63:0] bus_rdata, tbl_data;
  logic [10:0] reg_rd_idx, wide_idx;
  logic [127:0] reg_rd_data, wide_data;
  logic [11:0] tbl_idx;
  logic [1:0] nw_page, nw_sel;
  logic [31:0] nw_data;
  logic [7:0] gen = 8'd0;

  int vectors = 0, errors = 0;

  always #5 clk = ~clk;

  function automatic logic [127:0] live(input logic [10:0] idx, input logic [7:0] g);
    logic [127:0] v;
    for (int k = 0; k < 4; k++) v[k*32 +: 32] = {g, 4'(k), 4'h9, 5'h0, idx};
    return v;
  endfunction

  assign reg_rd_data = live(reg_rd_idx, gen);

  wide_wr_collector u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
    .wide_we(wide_we), .wide_idx(wide_idx), .wide_data(wide_data),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
    .nw_we(nw_we), .nw_page(nw_page), .nw_sel(nw_sel), .nw_data(nw_data));

  logic [95:0] m_stg = '0;
  logic [10:0] m_slot = '0;
  logic [31:0] m_tstg = '0;
  logic [11:0] m_tslot = '0;
  logic [127:0] m_shadow = '0;

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  task automatic op(input bit w, input bit r, input logic [15:0] a, input logic [7:0] be,
                    input logic [63:0] d, input string tag);
    bit dw, qw, good, tbl, nw, fin, e_wwe, e_twe, e_nwe, e_rv, e_err;
    logic [10:0] slot; logic [11:0] ti; logic [1:0] ds;
    logic [95:0] b; logic [127:0] e_wd, lv; logic [63:0] e_td, e_rd; logic [1:0] e_sel;
    bit bad;
    dw = (be == 8'h0F) && (a[1:0] == 0);
    qw = (be == 8'hFF) && (a[2:0] == 0);
    good = dw || qw;
    tbl = a[15];
    nw = !tbl && dw && (a[12:0] == 13'h800 || a[12:0] == 13'h810 || a[12:0] == 13'h820);
    e_sel = (a[12:0] == 13'h800) ? 2'd0 : (a[12:0] == 13'h810) ? 2'd1 : 2'd2;
    slot = a[14:4]; ti = a[14:3]; ds = a[3:2];
    e_wwe = 0; e_twe = 0; e_nwe = 0; e_rv = 0; e_err = (w || r) && !good;
    e_wd = '0; e_td = '0; e_rd = '0;
    lv = live(slot, gen);
    if (w && good && !tbl && !nw) begin
      b = (slot == m_slot) ? m_stg : '0;
      fin = dw ? (ds == 3) : a[3];
      m_slot = slot;
      if (fin) begin
        e_wwe = 1; e_wd = dw ? {d[31:0], b} : {d, b[63:0]}; m_stg = '0;
      end else begin
        if (dw) b[ds*32 +: 32] = d[31:0]; else b[63:0] = d;
        m_stg = b;
      end
    end
    if (w && good && tbl) begin
      if (qw) begin e_twe = 1; e_td = d; end
      else if (a[2]) begin
        e_twe = 1; e_td = {d[31:0], (m_tslot == ti) ? m_tstg : 32'h0};
        m_tstg = '0; m_tslot = ti;
      end else begin m_tstg = d[31:0]; m_tslot = ti; end
    end
    if (w && nw) e_nwe = 1;
    if (r && !w && good) begin
      e_rv = 1;
      if (tbl) e_rd = '0;
      else if (dw ? ds == 0 : !a[3]) begin
        m_shadow = lv; e_rd = dw ? {32'h0, lv[31:0]} : lv[63:0];
      end else e_rd = dw ? {32'h0, m_shadow[ds*32 +: 32]} : m_shadow[127:64];
    end
    bus_wr = w; bus_rd = r; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    vectors++;
    bad = (wide_we !== e_wwe) || (tbl_we !== e_twe) || (nw_we !== e_nwe) ||
          (bus_rvalid !== e_rv) || (bus_err !== e_err);
    if (e_wwe) bad |= (wide_idx !== slot) || (wide_data !== e_wd);
    if (e_twe) bad |= (tbl_idx !== ti) || (tbl_data !== e_td);
    if (e_nwe) bad |= (nw_page !== a[14:13]) || (nw_sel !== e_sel) || (nw_data !== d[31:0]);
    if (e_rv) bad |= (bus_rdata !== e_rd);
    if (bad) begin
      errors++;
      $display("FAIL %s addr=%h: actual we=%b/%b/%b rv=%b err=%b widx=%h wd=%h td=%h nw=%h/%h/%h rd=%h; expected we=%b/%b/%b rv=%b err=%b widx=%h wd=%h td=%h nw=%h/%h/%h rd=%h",
        tag, a, wide_we, tbl_we, nw_we, bus_rvalid, bus_err, wide_idx, wide_data, tbl_data,
        nw_page, nw_sel, nw_data, bus_rdata, e_wwe, e_twe, e_nwe, e_rv, e_err, slot, e_wd,
        e_td, a[14:13], e_sel, d[31:0], e_rd);
    end
  endtask

  initial begin
    void'($urandom(32'd7219));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    vectors++;
    if ({wide_we, tbl_we, nw_we, bus_rvalid, bus_err} !== 5'b0) begin
      errors++;
      $display("FAIL R11 reset: actual strobes=%b expected 00000",
               {wide_we, tbl_we, nw_we, bus_rvalid, bus_err});
    end
    // R1 R2: four dwords, commit on the top one
    op(1, 0, 16'h0120, 8'h0F, 64'h11, "R2");
    op(1, 0, 16'h0124, 8'h0F, 64'h22, "R2");
    op(1, 0, 16'h0128, 8'h0F, 64'h33, "R2");
    op(1, 0, 16'h012C, 8'h0F, 64'h44, "R1");
    // R3 qword pieces
    op(1, 0, 16'h0230, 8'hFF, 64'hAAAA_BBBB_CCCC_DDDD, "R3");
    op(1, 0, 16'h0238, 8'hFF, 64'h1111_2222_3333_4444, "R3");
    // R6 bypass in the middle of a collection
    op(1, 0, 16'h0340, 8'h0F, 64'h5A5A, "R2");
    op(1, 0, 16'h2810, 8'h0F, 64'hFEED, "R6");
    op(1, 0, 16'h0344, 8'h0F, 64'h6B6B, "R2");
    op(1, 0, 16'h0348, 8'h0F, 64'h7C7C, "R2");
    op(1, 0, 16'h034C, 8'h0F, 64'h8D8D, "R6");
    // R4 slot switch and clear after commit
    op(1, 0, 16'h0400, 8'h0F, 64'h99, "R4");
    op(1, 0, 16'h041C, 8'h0F, 64'h77, "R4");
    op(1, 0, 16'h041C, 8'h0F, 64'h78, "R4");
    // R5 table
    op(1, 0, 16'h8010, 8'h0F, 64'hCAFE, "R5");
    op(1, 0, 16'h8014, 8'h0F, 64'hBEEF, "R5");
    op(1, 0, 16'h8014, 8'h0F, 64'h1234, "R5");
    op(1, 0, 16'h8028, 8'hFF, 64'h0123_4567_89AB_CDEF, "R5");
    // R7 paging
    op(1, 0, 16'h6FFC, 8'h0F, 64'h31, "R7");
    op(1, 0, 16'h6820, 8'h0F, 64'h4242, "R7");
    // R10 bad enables inside a collection
    op(1, 0, 16'h0500, 8'h0F, 64'h10, "R10");
    op(1, 0, 16'h0504, 8'h03, 64'hDEAD, "R10");
    op(1, 0, 16'h0504, 8'hFF, 64'hDEAD, "R10");
    op(0, 1, 16'h0502, 8'h0F, 64'h0, "R10");
    op(1, 0, 16'h050C, 8'h0F, 64'h40, "R10");
    // R8 snapshot consistency
    gen = 8'd1;
    op(0, 1, 16'h0120, 8'h0F, 64'h0, "R8");
    gen = 8'd2;
    op(0, 1, 16'h0124, 8'h0F, 64'h0, "R8");
    op(0, 1, 16'h0128, 8'h0F, 64'h0, "R8");
    op(0, 1, 16'h012C, 8'h0F, 64'h0, "R8");
    op(0, 1, 16'h0130, 8'hFF, 64'h0, "R8");
    gen = 8'd3;
    op(0, 1, 16'h0138, 8'hFF, 64'h0, "R8");
    // R9 stale shadow
    op(0, 1, 16'h0554, 8'h0F, 64'h0, "R9");
    // R11 table read
    op(0, 1, 16'h8000, 8'hFF, 64'h0, "R11");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int kind; logic [15:0] a; logic [15:0] bases [3];
      bases[0] = 16'h0100; bases[1] = 16'h0110; bases[2] = 16'h2100;
      kind = $urandom % 6;
      gen = 8'($urandom);
      a = bases[$urandom % 3] | 16'({$urandom % 4, 2'b00});
      case (kind)
        0, 1: op(1, 0, a, 8'h0F, {$urandom, $urandom}, "R1");
        2: op(1, 0, a & 16'hFFF8, 8'hFF, {$urandom, $urandom}, "R3");
        3: op(1, 0, 16'({$urandom % 4, 13'h800}) + 16'(($urandom % 3) * 16), 8'h0F,
              {$urandom, $urandom}, "R6");
        4: op(0, 1, a, ($urandom % 2) ? 8'h0F : 8'hFF, 64'h0, "R8");
        default: begin
          if ($urandom % 2)
            op(1, 0, 16'h8000 | 16'({$urandom % 8, 2'b00}), 8'h0F, {$urandom, $urandom}, "R5");
          else
            op(1, 0, a, 8'($urandom % 255), {$urandom, $urandom}, "R10");
        end
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule